// File: doc/BRIEF.md
# Deglitched Two-Wire Configuration Register Slave

This block is a two-wire serial slave that gives a host read and write access to a bank of 8-bit configuration registers. Both bus lines are sampled with a local reference clock, passed through a synchronizer, and cleaned by a three-sample agreement filter. The protocol engine works only on the filtered lines. It detects START, repeated START and STOP conditions, matches a 7-bit device address whose lowest bit comes from a strap input, and acknowledges bytes. It moves data through an 8-bit register pointer that advances by one after every register access.

The register bank sits outside the block, behind a simple port. The block presents the pointer as the register address. It pulses a one-cycle write strobe with the byte to store, and during reads it takes the read data combinationally from the addressed register. SDA is never driven high. The block only asserts a pull-down enable, and the board's pull-up supplies the high level.

Top module: `twowire_cfg_slave`

## Requirements
- R1: While reset is applied and after it is released, the SDA pull-down enable is 0 and the write strobe is 0.
- R2: The device address is the 7-bit value 100110 followed by the strap input as its LSB. It is sent MSB first, followed by a direction bit (1 = read, 0 = write). On a match the slave pulls SDA low during the ninth clock (ACK).
- R3: On an address mismatch the slave gives no ACK, issues no write strobe and drives nothing until the next START.
- R4: Bus clocking before any START has been seen is ignored: no ACK and no write strobe.
- R5: In a write transfer, the first byte after the address loads the pointer and is not stored. Every later byte is written to the register at the pointer, and the pointer then advances by one, wrapping from 0xFF to 0x00.
- R6: A read transfer returns the register at the pointer, MSB first, then advances the pointer. A host ACK after a byte makes the slave send the next register.
- R7: A host NACK after a read byte makes the slave release SDA and ignore further clocks until STOP or START.
- R8: A repeated START ends the current transfer without a STOP and allows a change of direction. The pointer loaded by a preceding write is kept for a following read.
- R9: A STOP (SDA rising while the filtered SCL is high) returns the slave to idle with SDA released.
- R10: A pulse on SCL or SDA lasting fewer than three reference-clock periods is not taken as a clock edge or a bus condition.
- R11: The pull-down enable changes only while the filtered SCL is low, that is, after its falling edge.
- R12: A write strobe is issued in the same cycle in which the slave starts driving the ACK for that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_sel_i | input | 1 | Strap giving the LSB of the device address |
| sda_pull_o | output | 1 | 1 = pull SDA low; 0 = release |
| reg_addr_o | output | 8 | Register pointer, used as register-file address |
| reg_wdata_o | output | 8 | Byte to store when the strobe is high |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Read data of the register at reg_addr_o |

## Verification
Two things happen on the same filtered falling edge of SCL. The register write strobe and the start of the ACK drive both occur there, and the pointer advance follows in the very next cycle. Back-to-back multi-byte writes, including one that wraps the pointer past 0xFF, put these together repeatedly. A scoreboard matches each strobe against the expected address and data, and a read-back over a repeated START must return those bytes in order. In a second case, filter rejection and condition detection meet: two-cycle spikes are injected on SCL during a low phase and on SDA during a high phase. Each one would otherwise count as an extra bit or a false START and STOP, so a clean read-back shows that it was rejected.

// File: rtl/twc_pkg.sv
package twc_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [5:0]  DEV_ADDR_HI = 6'b100110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_HOLD
  } twc_state_e;
endpackage

// File: rtl/twc_filter.sv
module twc_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_WIN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_WIN-1:0]    win_q;
  logic                   out_q, out_d;

  // output follows only when the whole window agrees
  always_comb begin
    out_d = out_q;
    if (&win_q)       out_d = 1'b1;
    else if (~|win_q) out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      win_q  <= {win_q[FILT_WIN-2:0], sync_q[SYNC_STAGES-1]};
      out_q  <= out_d;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/twc_edges.sv
module twc_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/twc_engine.sv
module twc_engine
  import twc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic              sda_s,
  input  logic              addr_sel,
  input  logic [BYTE_W-1:0] rdata,
  output logic              pull,
  output logic              we,
  output logic [BYTE_W-1:0] addr,
  output logic [BYTE_W-1:0] wdata
);
  twc_state_e        state_q, state_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic              first_q, first_d;
  logic              rw_q, rw_d;
  logic              nack_q, nack_d;
  logic              pull_q, pull_d;
  logic              we_q, we_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    first_d = first_q;
    rw_d    = rw_q;
    nack_d  = nack_q;
    pull_d  = pull_q;
    we_d    = 1'b0;
    // pointer advances the cycle after a stored byte
    if (we_q) ptr_d = ptr_q + 1'b1;

    if (start_c) begin
      state_d = ST_ADDR;
      cnt_d   = 4'd0;
      pull_d  = 1'b0;
      first_d = 1'b1;
    end else if (stop_c) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (sh_q[7:1] == {DEV_ADDR_HI, addr_sel}) begin
              pull_d  = 1'b1;
              rw_d    = sh_q[0];
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = 4'd0;
            if (rw_q) begin
              sh_d    = rdata;
              pull_d  = ~rdata[BYTE_W-1];
              ptr_d   = ptr_q + 1'b1;
              state_d = ST_RD;
            end else begin
              pull_d  = 1'b0;
              state_d = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            pull_d  = 1'b1;
            state_d = ST_WR_ACK;
            if (first_q) begin
              ptr_d   = sh_q;
              first_d = 1'b0;
            end else begin
              we_d = 1'b1;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            cnt_d   = 4'd0;
            state_d = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              pull_d  = 1'b0;
              state_d = ST_RD_ACK;
            end else begin
              sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
              pull_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            cnt_d = 4'd0;
            if (nack_q) begin
              pull_d  = 1'b0;
              state_d = ST_HOLD;
            end else begin
              sh_d    = rdata;
              pull_d  = ~rdata[BYTE_W-1];
              ptr_d   = ptr_q + 1'b1;
              state_d = ST_RD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 4'd0;
      sh_q    <= '0;
      ptr_q   <= '0;
      first_q <= 1'b1;
      rw_q    <= 1'b0;
      nack_q  <= 1'b1;
      pull_q  <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      first_q <= first_d;
      rw_q    <= rw_d;
      nack_q  <= nack_d;
      pull_q  <= pull_d;
      we_q    <= we_d;
    end
  end

  assign pull  = pull_q;
  assign we    = we_q;
  assign addr  = ptr_q;
  assign wdata = sh_q;
endmodule

// File: rtl/twowire_cfg_slave.sv
module twowire_cfg_slave
  import twc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_WIN    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  localparam int unsigned NUM_LINES = 2;

  logic [1:0]           rst_pipe;
  logic                 rst_int_n;
  logic [NUM_LINES-1:0] raw, filt;
  logic                 scl_f, sda_f;
  logic                 scl_rise, scl_fall, start_c, stop_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    twc_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_WIN(FILT_WIN)) u_filt (
      .clk  (clk),
      .rst_n(rst_int_n),
      .din  (raw[g]),
      .dout (filt[g])
    );
  end

  assign scl_f = filt[0];
  assign sda_f = filt[1];

  twc_edges u_edges (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_c (start_c),
    .stop_c  (stop_c)
  );

  twc_engine u_engine (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_c (start_c),
    .stop_c  (stop_c),
    .sda_s   (sda_f),
    .addr_sel(addr_sel_i),
    .rdata   (reg_rdata_i),
    .pull    (sda_pull_o),
    .we      (reg_we_o),
    .addr    (reg_addr_o),
    .wdata   (reg_wdata_o)
  );
endmodule

// File: rtl/twc_slave_chk.sv
module twc_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       sda_f,
  input logic       sda_pull_o,
  input logic       reg_we_o,
  input logic [7:0] reg_addr_o
);
  assert_drive_on_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_f);

  assert_ack_with_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> sda_pull_o);

  assert_ptr_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> (reg_addr_o == $past(reg_addr_o) + 8'd1));

  assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f) && $rose(sda_f)) |=> !sda_pull_o);

  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);
endmodule

bind twowire_cfg_slave twc_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_f     (scl_f),
  .sda_f     (sda_f),
  .sda_pull_o(sda_pull_o),
  .reg_we_o  (reg_we_o),
  .reg_addr_o(reg_addr_o)
);

// File: tb/tb_twowire_cfg_slave.sv
module tb_twowire_cfg_slave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       scl = 1'b1;
  logic       sda_h = 1'b1;
  logic       addr_sel = 1'b0;
  logic       sda_pull;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we;
  logic       sda_bus;

  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  logic [15:0] exp_q [$];
  logic [7:0]  bptr;
  int vec_cnt = 0;
  int miss_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign sda_bus   = sda_h & ~sda_pull;
  assign reg_rdata = mem[reg_addr];

  twowire_cfg_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .addr_sel_i(addr_sel), .sda_pull_o(sda_pull),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 37 + 17);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    vec_cnt++;
    if (!ok) begin
      miss_cnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: register bank model and scoreboard of write strobes
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    end else if (reg_we) begin
      mem[reg_addr] = reg_wdata;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R4/R5 unexpected write", {reg_addr, reg_wdata}, 16'h0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check({reg_addr, reg_wdata} == e, "R5 write strobe", {reg_addr, reg_wdata}, e);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic b, input bit glitch, output logic rb);
    wait_n(8);
    sda_h = b;
    if (glitch) begin
      wait_n(2); scl = 1'b1; wait_n(2); scl = 1'b0; wait_n(4);
    end else wait_n(8);
    scl = 1'b1;
    if (glitch && b) begin
      wait_n(3); sda_h = 1'b0; wait_n(2); sda_h = 1'b1; wait_n(3);
    end else wait_n(8);
    rb = sda_bus;
    wait_n(8);
    scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
    logic rb;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], glitch, rb);
    bit_cycle(1'b1, 1'b0, rb);
    ack = ~rb;
  endtask

  task automatic recv_byte(input bit host_ack, output logic [7:0] d);
    logic rb;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bit_cycle(1'b1, 1'b0, rb);
      d = {d[6:0], rb};
    end
    bit_cycle(~host_ack, 1'b0, rb);
  endtask

  task automatic bus_start;
    sda_h = 1'b1; scl = 1'b1; wait_n(16);
    sda_h = 1'b0; wait_n(16);
    scl = 1'b0;
  endtask

  task automatic bus_rstart;
    wait_n(8); sda_h = 1'b1; wait_n(8); scl = 1'b1; wait_n(16);
    sda_h = 1'b0; wait_n(16); scl = 1'b0;
  endtask

  task automatic bus_stop;
    wait_n(8); sda_h = 1'b0; wait_n(8); scl = 1'b1; wait_n(16);
    sda_h = 1'b1; wait_n(16);
  endtask

  // driver: sends a data byte and pushes its expected store
  task automatic wr_data(input logic [7:0] b, input bit glitch, input string tag);
    logic ack;
    exp_q.push_back({bptr, b});
    exp_mem[bptr] = b;
    bptr = bptr + 8'd1;
    send_byte(b, glitch, ack);
    check(ack == 1'b1, tag, {15'd0, ack}, 16'd1);
  endtask

  task automatic rd_check(input bit host_ack, input string tag);
    logic [7:0] d;
    recv_byte(host_ack, d);
    check(d == exp_mem[bptr], tag, {8'd0, d}, {8'd0, exp_mem[bptr]});
    bptr = bptr + 8'd1;
  endtask

  task automatic set_ptr(input logic [7:0] devw, input logic [7:0] p);
    logic ack;
    bus_start;
    send_byte(devw, 1'b0, ack);
    check(ack == 1'b1, "R2 address ack", {15'd0, ack}, 16'd1);
    send_byte(p, 1'b0, ack);
    check(ack == 1'b1, "R5 pointer ack", {15'd0, ack}, 16'd1);
    bptr = p;
  endtask

  task automatic finish_run;
    if (exp_q.size() != 0) check(1'b0, "R5 missing write", 16'(exp_q.size()), 16'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    done = 1;
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 16'd0, 16'd1);
      finish_run;
    end
  end

  initial begin
    logic ack, rb;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    bptr = 8'd0;
    #1 rst_n = 1'b0;
    wait_n(3);
    check(sda_pull == 1'b0 && reg_we == 1'b0, "R1 in reset", {sda_pull, reg_we}, 16'd0);
    rst_n = 1'b1;
    wait_n(10);
    check(sda_pull == 1'b0 && reg_we == 1'b0, "R1 after reset", {sda_pull, reg_we}, 16'd0);

    // R4: a full address byte clocked without START
    scl = 1'b0; wait_n(16);
    for (int i = 7; i >= 0; i--) bit_cycle(8'h98 >> i, 1'b0, rb);
    bit_cycle(1'b1, 1'b0, rb);
    check(rb == 1'b1, "R4 no ack without START", {15'd0, rb}, 16'd1);
    wait_n(8); scl = 1'b1; wait_n(16);

    // R2 R5 R12: pointer then three stored bytes, strap 0 -> 0x98
    set_ptr(8'h98, 8'h10);
    wr_data(8'hA5, 1'b0, "R12 ack data0");
    wr_data(8'h5A, 1'b0, "R12 ack data1");
    wr_data(8'h3C, 1'b0, "R12 ack data2");
    bus_stop;
    check(sda_pull == 1'b0, "R9 released after stop", {15'd0, sda_pull}, 16'd0);

    // R8 R6 R7: pointer write, repeated START, sequential read
    set_ptr(8'h98, 8'h10);
    bus_rstart;
    send_byte(8'h99, 1'b0, ack);
    check(ack == 1'b1, "R8 read address ack", {15'd0, ack}, 16'd1);
    rd_check(1'b1, "R8 read after rstart");
    rd_check(1'b1, "R6 sequential read 1");
    rd_check(1'b0, "R6 sequential read 2");
    recv_byte(1'b1, d);
    check(d == 8'hFF, "R7 released after NACK", {8'd0, d}, 16'h00FF);
    bus_stop;

    // R6: unwritten registers read with auto increment
    set_ptr(8'h98, 8'h40);
    bus_rstart;
    send_byte(8'h99, 1'b0, ack);
    rd_check(1'b1, "R6 default reg 0x40");
    rd_check(1'b0, "R6 default reg 0x41");
    bus_stop;

    // R3: strap 0, address LSB 1 -> no ack, no store
    bus_start;
    send_byte(8'h9A, 1'b0, ack);
    check(ack == 1'b0, "R3 mismatch no ack", {15'd0, ack}, 16'd0);
    send_byte(8'h20, 1'b0, ack);
    check(ack == 1'b0, "R3 ignored after mismatch", {15'd0, ack}, 16'd0);
    send_byte(8'hEE, 1'b0, ack);
    check(ack == 1'b0, "R3 ignored data", {15'd0, ack}, 16'd0);
    bus_stop;

    // R2: strap 1 -> 0x9A answers, 0x98 does not
    addr_sel = 1'b1;
    wait_n(16);
    bus_start;
    send_byte(8'h98, 1'b0, ack);
    check(ack == 1'b0, "R2 strap 1 rejects LSB 0", {15'd0, ack}, 16'd0);
    bus_stop;

    // R10 R5: writes with spikes on both lines, pointer wrap at 0xFF
    set_ptr(8'h9A, 8'hFF);
    wr_data(8'h81, 1'b1, "R10 glitched byte 0");
    wr_data(8'h6E, 1'b1, "R10 glitched byte 1 wrap");
    bus_stop;
    set_ptr(8'h9A, 8'hFF);
    bus_rstart;
    send_byte(8'h9B, 1'b0, ack);
    rd_check(1'b1, "R10 read glitched 0");
    rd_check(1'b1, "R5 read after wrap");
    rd_check(1'b0, "R3 reg 0x01 untouched");
    bus_stop;

    set_ptr(8'h9A, 8'h20);
    bus_rstart;
    send_byte(8'h9B, 1'b0, ack);
    rd_check(1'b0, "R3 reg 0x20 untouched");
    bus_stop;

    wait_n(20);
    finish_run;
  end
endmodule